// File: doc/BRIEF.md
# Serial Command Decoder for a 16-bit Converter

This block is the register side of a 16-bit digital-to-analog converter, controlled over a four-wire serial link in SPI mode 0. Every transaction is a 24-bit frame, most significant bit first: a command byte followed by a 16-bit data word. The low nibble of the command byte selects the operation. The command runs when chip-select returns high, and only if exactly 24 serial clocks arrived while chip-select was low.

The converter code is double-buffered. The host can stage a value in an input register, load the input and output registers together, or move the staged value into the output register. Other commands write a control word, a 16-bit clear value and a full-scale trim word. Read commands copy a register into the shift register. The host clocks that value out of the serial data output during its next frame. Commands that do not read leave the shift register as it is, so the next frame returns the frame just sent.

The serial pins are sampled with the system clock. The serial clock must stay at or below one eighth of the system clock.

Top module: `dac_spi_cmd`

## Requirements
- R1: Bit 23 of a frame comes first. The command byte is frame bits [23:16] and the data word is bits [15:0]. The opcode is bits [19:16], and bits [23:20] have no effect on what runs.
- R2: A command runs only when chip-select rises after exactly 24 rising serial-clock edges. A frame with 23 or 25 edges changes no register.
- R3: Opcode 0011 writes the data word to the input register and leaves `dac_o` unchanged.
- R4: Opcode 0100 writes the data word to both the input register and `dac_o`.
- R5: Opcode 0101 copies the input register to `dac_o`. Its data word is ignored.
- R6: Opcode 0000 writes data bits [5:0] to `ctrl_o`, which holds {bipolar, clear mode, fault enable, clear enable, current-out enable, voltage-out enable} from bit 5 down to bit 0. Opcode 0001 reads the control word back, zero-extended to 16 bits.
- R7: Opcode 0110 writes the 16-bit clear register, and opcode 1001 reads it back.
- R8: Opcode 1010 writes the trim word: data bit 10 drives `trim_en_o` and data bits [9:0] drive `trim_o`.
- R9: Opcodes 0001, 0111, 1000 and 1001 replace shift-register bits [15:0] with the control, input, DAC or clear register, in that order, and keep bits [23:16]. During the next frame, the whole 24-bit shift register appears MSB first on `dout_o`.
- R10: All other commands leave the shift register unchanged, so the next frame returns the previous frame unchanged on `dout_o`.
- R11: Opcodes 0010 and 1011 to 1111 are no-ops.
- R12: Reset clears every register and the shift register. `dout_o` is low whenever chip-select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock; data is taken on its rising edge |
| cs_ni | input | 1 | Chip-select, active low |
| din_i | input | 1 | Serial data in |
| dout_o | output | 1 | Serial data out |
| dac_o | output | 16 | Output (DAC) register |
| ctrl_o | output | 6 | Control word |
| trim_en_o | output | 1 | Full-scale trim enable |
| trim_o | output | 10 | Full-scale trim value |

## Verification
If the bit count or the frame check goes wrong, a write is dropped or a bad frame runs. Either shows on `dac_o`, `ctrl_o` or the trim outputs within a few clocks after chip-select rises. A wrong read multiplexer, or a write that disturbs the shift register, only shows one frame later on `dout_o`. For that reason every frame's returned bits are compared with the frame before it. The staged input register cannot be seen directly. Its state is brought out through the transfer command and through an input-register read.

// File: rtl/dac_spi_pkg.sv
package dac_spi_pkg;
  localparam int CMD_W   = 8;
  localparam int DATA_W  = 16;
  localparam int OP_W    = 4;
  localparam int FRAME_W = CMD_W + DATA_W;
  localparam int TRIM_W  = 10;
  localparam int CTRL_W  = 6;

  typedef enum logic [OP_W-1:0] {
    OP_CTRL_WR = 4'h0,
    OP_CTRL_RD = 4'h1,
    OP_LD_IN   = 4'h3,
    OP_LD_BOTH = 4'h4,
    OP_XFER    = 4'h5,
    OP_CLR_WR  = 4'h6,
    OP_IN_RD   = 4'h7,
    OP_DAC_RD  = 4'h8,
    OP_CLR_RD  = 4'h9,
    OP_TRIM_WR = 4'hA
  } op_e;

  typedef struct packed {
    logic bipolar;
    logic clr_mode;
    logic fault_en;
    logic clr_en;
    logic out_i_en;
    logic out_v_en;
  } ctrl_t;
endpackage

// File: rtl/dac_spi_sync.sv
module dac_spi_sync #(
  parameter int          N      = 3,
  parameter int          STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {(STAGES+1){RST_VAL[b]}};
      else         chain_q <= {chain_q[STAGES-1:0], async_i[b]};
    end
    // chain_q[STAGES] is the delayed copy used for edge detection
    assign sync_o[b] = chain_q[STAGES-1];
    assign rise_o[b] = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o[b] = ~chain_q[STAGES-1] & chain_q[STAGES];
  end
endmodule

// File: rtl/dac_spi_shift.sv
module dac_spi_shift
  import dac_spi_pkg::*;
#(
  parameter int W   = FRAME_W,
  parameter int LDW = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_act_i,
  input  logic         cs_fall_i,
  input  logic         cs_rise_i,
  input  logic         sclk_rise_i,
  input  logic         din_i,
  input  logic         load_i,
  input  logic [LDW-1:0] load_data_i,
  output logic [W-1:0] frame_o,
  output logic         frame_ok_o,
  output logic         dout_o
);
  localparam int CNT_W = $clog2(W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(W);

  logic [W-1:0]     sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             dout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cs_fall_i) begin
      cnt_q <= '0;
    end else if (cs_act_i && sclk_rise_i && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else if (load_i) begin
      sh_q[LDW-1:0] <= load_data_i;
    end else if (cs_act_i && sclk_rise_i) begin
      sh_q <= {sh_q[W-2:0], din_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dout_q <= 1'b0;
    else         dout_q <= cs_act_i & sh_q[W-1];
  end

  assign frame_o    = sh_q;
  assign frame_ok_o = cs_rise_i && (cnt_q == CNT_FULL);
  assign dout_o     = dout_q;
endmodule

// File: rtl/dac_spi_regs.sv
module dac_spi_regs
  import dac_spi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] inp_o,
  output logic [DATA_W-1:0] dac_o,
  output ctrl_t             ctrl_o,
  output logic              trim_en_o,
  output logic [TRIM_W-1:0] trim_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] inp_q, dac_q, clr_q;
  ctrl_t             ctrl_q;
  logic              trim_en_q;
  logic [TRIM_W-1:0] trim_q;
  op_e               op;

  assign op = op_e'(op_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inp_q     <= '0;
      dac_q     <= '0;
      clr_q     <= '0;
      ctrl_q    <= '0;
      trim_en_q <= 1'b0;
      trim_q    <= '0;
    end else if (exec_i) begin
      case (op)
        OP_CTRL_WR: ctrl_q <= ctrl_t'(data_i[CTRL_W-1:0]);
        OP_LD_IN:   inp_q  <= data_i;
        OP_LD_BOTH: begin
          inp_q <= data_i;
          dac_q <= data_i;
        end
        OP_XFER:    dac_q  <= inp_q;
        OP_CLR_WR:  clr_q  <= data_i;
        OP_TRIM_WR: begin
          trim_en_q <= data_i[TRIM_W];
          trim_q    <= data_i[TRIM_W-1:0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_valid_o = 1'b1;
    rd_data_o  = '0;
    case (op)
      OP_CTRL_RD: rd_data_o = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      OP_IN_RD:   rd_data_o = inp_q;
      OP_DAC_RD:  rd_data_o = dac_q;
      OP_CLR_RD:  rd_data_o = clr_q;
      default:    rd_valid_o = 1'b0;
    endcase
  end

  assign inp_o     = inp_q;
  assign dac_o     = dac_q;
  assign ctrl_o    = ctrl_q;
  assign trim_en_o = trim_en_q;
  assign trim_o    = trim_q;
endmodule

// File: rtl/dac_spi_cmd.sv
module dac_spi_cmd
  import dac_spi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              din_i,
  output logic              dout_o,
  output logic [DATA_W-1:0] dac_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              trim_en_o,
  output logic [TRIM_W-1:0] trim_o
);
  localparam int PIN_N = 3;
  localparam int PIN_SCLK = 0;
  localparam int PIN_CS   = 1;
  localparam int PIN_DIN  = 2;

  logic [PIN_N-1:0] pin_sync, pin_rise, pin_fall;
  logic              cs_act, exec, rd_valid;
  logic [FRAME_W-1:0] frame;
  logic [OP_W-1:0]   op;
  logic [DATA_W-1:0] rd_data, inp_q;
  ctrl_t             ctrl_s;

  dac_spi_sync #(.N(PIN_N), .STAGES(2), .RST_VAL(3'b010)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({din_i, cs_ni, sclk_i}),
    .sync_o (pin_sync),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  assign cs_act = ~pin_sync[PIN_CS];
  assign op     = frame[DATA_W +: OP_W];

  dac_spi_shift u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_act_i   (cs_act),
    .cs_fall_i  (pin_fall[PIN_CS]),
    .cs_rise_i  (pin_rise[PIN_CS]),
    .sclk_rise_i(pin_rise[PIN_SCLK]),
    .din_i      (pin_sync[PIN_DIN]),
    .load_i     (exec & rd_valid),
    .load_data_i(rd_data),
    .frame_o    (frame),
    .frame_ok_o (exec),
    .dout_o     (dout_o)
  );

  dac_spi_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .exec_i    (exec),
    .op_i      (op),
    .data_i    (frame[DATA_W-1:0]),
    .inp_o     (inp_q),
    .dac_o     (dac_o),
    .ctrl_o    (ctrl_s),
    .trim_en_o (trim_en_o),
    .trim_o    (trim_o),
    .rd_valid_o(rd_valid),
    .rd_data_o (rd_data)
  );

  assign ctrl_o = ctrl_s;
  logic unused_pins;
  assign unused_pins = ^{pin_rise[PIN_DIN], pin_fall[PIN_DIN], pin_fall[PIN_SCLK]};
endmodule

// File: rtl/dac_spi_cmd_chk.sv
module dac_spi_cmd_chk
  import dac_spi_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              exec_i,
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W-1:0] inp_i,
  input logic              cs_act_i,
  input logic              dout_i,
  input logic [DATA_W-1:0] dac_i,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic [TRIM_W:0]   trim_i
);
  assert_dac_needs_exec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dac_i) |-> $past(exec_i));

  assert_ctrl_needs_exec_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_i) |-> $past(exec_i) && $past(op_i) == OP_CTRL_WR);

  assert_trim_needs_exec_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(trim_i) |-> $past(exec_i) && $past(op_i) == OP_TRIM_WR);

  assert_load_both_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i && op_i == OP_LD_BOTH |=> dac_i == $past(data_i) && inp_i == $past(data_i));

  assert_xfer_copies_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i && op_i == OP_XFER |=> dac_i == $past(inp_i));

  assert_load_in_keeps_dac_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_i && op_i == OP_LD_IN |=> $stable(dac_i));

  assert_dout_idle_low_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> !dout_i);
endmodule

bind dac_spi_cmd dac_spi_cmd_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .exec_i  (exec),
  .op_i    (op),
  .data_i  (frame[15:0]),
  .inp_i   (inp_q),
  .cs_act_i(cs_act),
  .dout_i  (dout_o),
  .dac_i   (dac_o),
  .ctrl_i  (ctrl_o),
  .trim_i  ({trim_en_o, trim_o})
);

// File: tb/dac_spi_cmd_bench.sv
module dac_spi_cmd_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int NVEC = 15;

  logic clk = 0, rst_ni = 0, sclk = 0, cs_n = 1, din = 0;
  logic dout;
  logic [15:0] dac;
  logic [5:0]  ctrl;
  logic        trim_en;
  logic [9:0]  trim;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_spi_cmd u_dac_spi_cmd (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_ni(cs_n), .din_i(din),
    .dout_o(dout), .dac_o(dac), .ctrl_o(ctrl), .trim_en_o(trim_en), .trim_o(trim)
  );

  // {cmd, data, expected dout of this frame, dac after, ctrl after}
  localparam logic [69:0] VEC [NVEC] = '{
    {8'h03, 16'h1234, 24'h000000, 16'h0000, 6'h00}, // R3 load input
    {8'hF7, 16'h0000, 24'h031234, 16'h0000, 6'h00}, // R1 upper nibble ignored, R10 echo
    {8'h05, 16'hFFFF, 24'hF71234, 16'h1234, 6'h00}, // R5 transfer, R9 input read
    {8'h04, 16'hABCD, 24'h05FFFF, 16'hABCD, 6'h00}, // R4
    {8'h08, 16'h0000, 24'h04ABCD, 16'hABCD, 6'h00},
    {8'h06, 16'h5A5A, 24'h08ABCD, 16'hABCD, 6'h00}, // R7, R9 dac read
    {8'h09, 16'h0000, 24'h065A5A, 16'hABCD, 6'h00},
    {8'h0B, 16'h7777, 24'h095A5A, 16'hABCD, 6'h00}, // R11, R7 clear read
    {8'h02, 16'h1111, 24'h0B7777, 16'hABCD, 6'h00}, // R11
    {8'h03, 16'h2222, 24'h021111, 16'hABCD, 6'h00}, // R3
    {8'h07, 16'h0000, 24'h032222, 16'hABCD, 6'h00},
    {8'h00, 16'h0015, 24'h072222, 16'hABCD, 6'h15}, // R6
    {8'h01, 16'h0000, 24'h000015, 16'hABCD, 6'h15},
    {8'h0A, 16'h0755, 24'h010015, 16'hABCD, 6'h15}, // R8, R6 read
    {8'h00, 16'h0000, 24'h0A0755, 16'hABCD, 6'h00}
  };

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] c, input logic [15:0] d, input int nbits,
                      output logic [23:0] got);
    logic [23:0] w;
    w = {c, d};
    got = '0;
    cs_n = 0;
    wait_clks(HALF);
    for (int i = 0; i < nbits; i++) begin
      din = (i < 24) ? w[23-i] : 1'b0;
      wait_clks(HALF);
      if (i < 24) got[23-i] = dout;
      sclk = 1;
      wait_clks(HALF);
      sclk = 0;
    end
    wait_clks(HALF);
    cs_n = 1;
    wait_clks(10);
    din = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [23:0] got;
    wait_clks(3);
    chk("R12 reset dac", 32'(dac), 0);
    chk("R12 reset dout", 32'(dout), 0);
    rst_ni = 1;
    wait_clks(3);

    for (int v = 0; v < NVEC; v++) begin
      send(VEC[v][69:62], VEC[v][61:46], 24, got);
      chk("R9/R10 dout", 32'(got), 32'(VEC[v][45:22]));
      chk("R3/R4/R5 dac", 32'(dac), 32'(VEC[v][21:6]));
      chk("R6 ctrl", 32'(ctrl), 32'(VEC[v][5:0]));
    end
    chk("R8 trim enable", 32'(trim_en), 1);
    chk("R8 trim value", 32'(trim), 32'h355);

    // no-op leaves a 1 in shift MSB; dout must still be low with cs high
    send(8'hF2, 16'h0000, 24, got);
    chk("R12 dout idle", 32'(dout), 0);
    chk("R11 no-op dac", 32'(dac), 32'hABCD);

    send(8'h04, 16'h9999, 23, got);
    chk("R2 short frame", 32'(dac), 32'hABCD);
    send(8'h04, 16'h9999, 25, got);
    chk("R2 long frame", 32'(dac), 32'hABCD);
    send(8'h05, 16'h0000, 24, got);
    chk("R2 input kept", 32'(dac), 32'h2222);

    send(8'h08, 16'h0000, 24, got);
    send(8'h00, 16'h0000, 24, got);
    chk("R9 dac read", 32'(got), 32'h082222);

    send(8'h0A, 16'h03FF, 24, got);
    chk("R8 trim off", 32'({trim_en, trim}), 32'h3FF);

    rst_ni = 0;
    wait_clks(2);
    chk("R12 reset dac", 32'(dac), 0);
    chk("R12 reset trim", 32'({trim_en, trim}), 0);
    chk("R12 reset ctrl", 32'(ctrl), 0);
    chk("R12 reset dout", 32'(dout), 0);
    rst_ni = 1;
    wait_clks(3);
    send(8'h00, 16'h0000, 24, got);
    chk("R12 shift cleared", 32'(got), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule